// File: doc/BRIEF.md
# Two-Channel Descriptor-Chained DMA Engine

The engine serves two independent DMA channels that share one word-wide register window and one memory request port. Software writes a descriptor's address into a channel and asks it to fetch. The channel then reads the four-word descriptor from memory and moves its data one 32-bit word at a time, reading from the source and writing to the destination. When the byte count runs out, the channel either stops or, in chain mode, fetches the descriptor that the next pointer names. A ring of descriptors therefore gives an endless cyclic transfer that raises a completion flag at every period, which suits audio-style streaming buffers.

A single sequencer owns the memory port. It grants the port to one channel for a whole burst at a time and alternates between requesting channels. Each channel can step or hold its source and destination addresses, so one side can be a fixed peripheral register. Software can pause a channel, resume it, or abort it at any time. A per-channel interrupt line reports completion when that channel's mask allows it.

Top module: `ringdma`

## Requirements
- R1: Each channel's registers sit at a block offset plus 4×channel. The offsets are: count 0x00, source 0x10, destination 0x20, next pointer 0x30, control 0x40, current descriptor 0x70, mask 0x80, status 0xA0. Writes to one channel do not change the other. The next pointer reads back with its low 4 bits forced to zero. Everything reads 0 after reset.
- R2: Writing control with bit 13 (fetch) and bit 12 (enable) set makes the channel read four words at the next pointer P: count, source, destination and next pointer, in that order. The current-descriptor register then reads P, and control bit 14 (active) reads 1 while the descriptor is loaded.
- R3: Each beat reads the 32-bit word at the source address and then writes it to the destination address, and the count drops by 4. All memory addresses are word aligned.
- R4: Control bits [3:2] give the source mode and bits [5:4] give the destination mode. Code 0 adds 4 after every beat; code 2 holds the address fixed.
- R5: Control bits [8:6] give the burst length that a channel keeps the port for: code 0 is 1 beat, 1 is 2, 3 is 4, 6 is 8, 7 is 16 and 5 is 32. The last burst of a descriptor moves only the words that remain.
- R6: When the count reaches zero, status bit 0 sets. The channel's irq output equals status bit 0 AND mask bit 0. Writing status with bit 0 clear clears it.
- R7: With control bit 9 (chain) clear, the channel clears enable and active at completion. With it set, the channel fetches the next descriptor and keeps running, so a ring of descriptors never stops.
- R8: Clearing enable pauses the channel: no further memory requests are made, the count holds, and active stays 1. Setting enable again resumes from the same point and produces the same data.
- R9: Writing control bit 20 (abort) stops the channel at the next beat boundary. Enable, active and abort then read 0, no completion is flagged, and no further requests are made.
- R10: When both channels want the port, grants alternate, starting with the channel not granted last.
- R11: A memory request holds its address, its direction and its write data unchanged until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid in the memAck cycle |
| memAck | input | 1 | Memory accepts the request this cycle |
| irq | output | NCH | Per-channel completion interrupt |

## Verification
The hardest cases to reach are a pause or an abort that lands in the middle of a running descriptor, and two channels contending with different burst lengths. To reach them, the bench counts write beats on the memory side and acts once a set number of beats has landed. It then checks that the port goes quiet and that the remaining count is frozen. For contention, the bench starts both channels within one cycle of each other and compares the exact order of destination regions in the write log with the sequence expected from the burst lengths and the alternating grant. The memory acknowledge stalls every third cycle, so every request must also hold its values across a wait.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 17;   // up to 64 KiB per descriptor
  localparam int CIW    = 2;    // channel index width (stride 4 allows 4)
  localparam int BEAT_B = DATA_W / 8;

  localparam logic [3:0] BLK_CNT = 4'h0;
  localparam logic [3:0] BLK_SRC = 4'h1;
  localparam logic [3:0] BLK_DST = 4'h2;
  localparam logic [3:0] BLK_NXT = 4'h3;
  localparam logic [3:0] BLK_CTL = 4'h4;
  localparam logic [3:0] BLK_CUR = 4'h7;
  localparam logic [3:0] BLK_MSK = 4'h8;
  localparam logic [3:0] BLK_STS = 4'hA;

  localparam logic [1:0] DIR_HOLD = 2'd2;

  typedef struct packed {
    logic           busy;
    logic [CIW-1:0] ch;
    logic           fetchLd;
    logic [1:0]     fetchIdx;
    logic           rdLatch;
    logic           beatDone;
  } strobe_t;

  typedef struct packed {
    logic              want;
    logic              needFetch;
    logic              en;
    logic              abortPend;
    logic              lastBeat;
    logic [2:0]        burst;
    logic [ADDR_W-1:0] fetchAddr;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } view_t;

  function automatic logic [5:0] burstBeats(input logic [2:0] code);
    case (code)
      3'd1:    return 6'd2;
      3'd3:    return 6'd4;
      3'd6:    return 6'd8;
      3'd7:    return 6'd16;
      3'd5:    return 6'd32;
      default: return 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/ringdma_dp.sv
module ringdma_dp
  import ringdma_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  input  strobe_t           stb,
  output view_t             view [NCH],
  output logic [NCH-1:0]    chMask,
  output logic [NCH-1:0]    irq
);
  logic [31:0] chRd [NCH];
  logic [DATA_W-1:0] beatBuf;

  always_ff @(posedge clk) begin
    if (!rstN)            beatBuf <= '0;
    else if (stb.rdLatch) beatBuf <= memRdata;
  end
  assign memWdata = beatBuf;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [3:0] SLOT = 4'(i * 4);
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] src, dst, nxt, cur;
    logic en, act, fetchPend, abortPend, chain, mask, istat;
    logic [2:0] burst;
    logic [1:0] sDir, dDir;
    logic hit, own;
    logic [31:0] ctlRd;

    assign hit = regWe && (regAddr[3:0] == SLOT);
    assign own = stb.busy && (stb.ch == CIW'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0; src <= '0; dst <= '0; nxt <= '0; cur <= '0;
        en <= 1'b0; act <= 1'b0; fetchPend <= 1'b0; abortPend <= 1'b0;
        chain <= 1'b0; mask <= 1'b0; istat <= 1'b0;
        burst <= '0; sDir <= '0; dDir <= '0;
      end else begin
        if (hit) begin
          case (regAddr[7:4])
            BLK_CNT: cnt <= regWdata[CNT_W-1:0];
            BLK_SRC: src <= regWdata;
            BLK_DST: dst <= regWdata;
            BLK_NXT: nxt <= {regWdata[31:4], 4'b0};
            BLK_CTL: begin
              en    <= regWdata[12];
              chain <= regWdata[9];
              burst <= regWdata[8:6];
              dDir  <= regWdata[5:4];
              sDir  <= regWdata[3:2];
              if (regWdata[13]) fetchPend <= 1'b1;
              if (regWdata[20]) abortPend <= 1'b1;
            end
            BLK_MSK: mask  <= regWdata[0];
            BLK_STS: istat <= istat & regWdata[0];
            default: ;
          endcase
        end
        if (own && stb.fetchLd) begin
          case (stb.fetchIdx)
            2'd0: begin cnt <= memRdata[CNT_W-1:0]; cur <= nxt; end
            2'd1: src <= memRdata;
            2'd2: dst <= memRdata;
            default: begin
              nxt <= {memRdata[31:4], 4'b0};
              fetchPend <= 1'b0;
              act <= 1'b1;
            end
          endcase
        end
        if (own && stb.beatDone) begin
          cnt <= cnt - CNT_W'(BEAT_B);
          if (sDir != DIR_HOLD) src <= src + ADDR_W'(BEAT_B);
          if (dDir != DIR_HOLD) dst <= dst + ADDR_W'(BEAT_B);
          if (cnt <= CNT_W'(BEAT_B)) begin
            if (!abortPend) istat <= 1'b1;
            if (chain) fetchPend <= 1'b1;
            else begin en <= 1'b0; act <= 1'b0; end
          end
        end
        if (abortPend && !own) begin
          en <= 1'b0; act <= 1'b0; fetchPend <= 1'b0; abortPend <= 1'b0;
        end
      end
    end

    always_comb begin
      ctlRd      = '0;
      ctlRd[20]  = abortPend;
      ctlRd[14]  = act;
      ctlRd[13]  = fetchPend;
      ctlRd[12]  = en;
      ctlRd[9]   = chain;
      ctlRd[8:6] = burst;
      ctlRd[5:4] = dDir;
      ctlRd[3:2] = sDir;
      case (regAddr[7:4])
        BLK_CNT: chRd[i] = 32'(cnt);
        BLK_SRC: chRd[i] = src;
        BLK_DST: chRd[i] = dst;
        BLK_NXT: chRd[i] = nxt;
        BLK_CTL: chRd[i] = ctlRd;
        BLK_CUR: chRd[i] = cur;
        BLK_MSK: chRd[i] = {31'b0, mask};
        BLK_STS: chRd[i] = {31'b0, istat};
        default: chRd[i] = '0;
      endcase
    end

    assign view[i].want      = en && !abortPend && (fetchPend || (act && cnt != '0));
    assign view[i].needFetch = fetchPend;
    assign view[i].en        = en;
    assign view[i].abortPend = abortPend;
    assign view[i].lastBeat  = (cnt <= CNT_W'(BEAT_B));
    assign view[i].burst     = burst;
    assign view[i].fetchAddr = nxt;
    assign view[i].src       = src;
    assign view[i].dst       = dst;
    assign chMask[i]         = mask;
    assign irq[i]            = istat & mask;
  end

  always_comb begin
    regRdata = '0;
    for (int k = 0; k < NCH; k++)
      if (regAddr[1:0] == 2'b0 && regAddr[3:2] == 2'(k)) regRdata = chRd[k];
  end
endmodule

// File: rtl/ringdma_ctrl.sv
module ringdma_ctrl
  import ringdma_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  view_t             view [NCH],
  input  logic              memAck,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output strobe_t           stb
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RD, S_WR} state_t;
  state_t state;
  logic [CIW-1:0] owner, lastGnt, pick;
  logic [1:0] idx;
  logic [5:0] burstLeft;
  logic found;

  always_comb begin
    found = 1'b0;
    pick  = lastGnt;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && view[(int'(lastGnt) + k) % NCH].want) begin
        found = 1'b1;
        pick  = CIW'((int'(lastGnt) + k) % NCH);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; owner <= '0; lastGnt <= CIW'(NCH - 1);
      idx <= '0; burstLeft <= '0;
    end else begin
      case (state)
        S_IDLE: if (found) begin
          owner   <= pick;
          lastGnt <= pick;
          idx     <= '0;
          if (view[pick].needFetch) state <= S_FETCH;
          else begin
            state     <= S_RD;
            burstLeft <= burstBeats(view[pick].burst);
          end
        end
        S_FETCH: if (memAck) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) state <= S_IDLE;
        end
        S_RD: if (memAck) state <= S_WR;
        S_WR: if (memAck) begin
          if (view[owner].lastBeat || view[owner].abortPend ||
              !view[owner].en || burstLeft == 6'd1)
            state <= S_IDLE;
          else begin
            burstLeft <= burstLeft - 6'd1;
            state     <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    memReq = (state != S_IDLE);
    memWe  = (state == S_WR);
    case (state)
      S_FETCH: memAddr = view[owner].fetchAddr + {28'b0, idx, 2'b00};
      S_RD:    memAddr = view[owner].src;
      S_WR:    memAddr = view[owner].dst;
      default: memAddr = '0;
    endcase
    stb.busy     = (state != S_IDLE);
    stb.ch       = owner;
    stb.fetchLd  = (state == S_FETCH) && memAck;
    stb.fetchIdx = idx;
    stb.rdLatch  = (state == S_RD) && memAck;
    stb.beatDone = (state == S_WR) && memAck;
  end
endmodule

// File: rtl/ringdma.sv
module ringdma
  import ringdma_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [7:0]     regAddr,
  input  logic           regWe,
  input  logic [31:0]    regWdata,
  output logic [31:0]    regRdata,
  output logic           memReq,
  output logic           memWe,
  output logic [31:0]    memAddr,
  output logic [31:0]    memWdata,
  input  logic [31:0]    memRdata,
  input  logic           memAck,
  output logic [NCH-1:0] irq
);
  strobe_t stb;
  view_t   view [NCH];
  logic [NCH-1:0] chMask, chEn, chAbort;
  logic engBusy;

  ringdma_dp #(.NCH(NCH)) u_dp (
    .clk, .rstN, .regAddr, .regWe, .regWdata, .regRdata,
    .memRdata, .memWdata, .stb, .view, .chMask, .irq
  );

  ringdma_ctrl #(.NCH(NCH)) u_ctrl (
    .clk, .rstN, .view, .memAck, .memReq, .memWe, .memAddr, .stb
  );

  for (genvar i = 0; i < NCH; i++) begin : g_tap
    assign chEn[i]    = view[i].en;
    assign chAbort[i] = view[i].abortPend;
  end
  assign engBusy = stb.busy;
endmodule

// File: rtl/ringdma_chk.sv
module ringdma_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           memReq,
  input logic           memWe,
  input logic           memAck,
  input logic [31:0]    memAddr,
  input logic [31:0]    memWdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] chMask,
  input logic [NCH-1:0] chEn,
  input logic [NCH-1:0] chAbort,
  input logic           engBusy
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_wdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !memAck |=> $stable(memWdata));

  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(memReq && !memWe && memAck));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_abort_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
      chAbort[i] && !engBusy |=> !chEn[i] && !chAbort[i]);

    assert_irq_after_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[i]) && $past(chMask[i]) |-> $past(memReq && memWe && memAck));
  end
endmodule

bind ringdma ringdma_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memWdata(memWdata), .irq(irq), .chMask(chMask),
  .chEn(chEn), .chAbort(chAbort), .engBusy(engBusy)
);

// File: tb/sim_ringdma.sv
module sim_ringdma;
  localparam int NCH = 2;
  localparam logic [7:0] A_CNT = 8'h00, A_SRC = 8'h10, A_DST = 8'h20, A_NXT = 8'h30,
                         A_CTL = 8'h40, A_CUR = 8'h70, A_MSK = 8'h80, A_STS = 8'hA0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [NCH-1:0] irq;

  always #10 clk = ~clk;

  ringdma #(.NCH(NCH)) u0 (
    .clk, .rstN, .regAddr, .regWe, .regWdata, .regRdata,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck, .irq
  );

  bit [31:0] mem [0:1023];
  bit        wlog [0:511];
  int logN = 0, reqCnt = 0, cyc = 0, ackPh = 0;
  logic pokeEn = 1'b0;
  logic [31:0] pokeAddr = '0, pokeData = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  assign memRdata = mem[memAddr[11:2]];
  assign memAck   = (ackPh != 2);

  always @(negedge clk) ackPh <= (ackPh == 2) ? 0 : ackPh + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memReq) reqCnt <= reqCnt + 1;
    if (memReq && memWe && memAck) begin
      mem[memAddr[11:2]] <= memWdata;
      if (logN < 512) wlog[logN] <= (memAddr >= 32'h500 && memAddr < 32'h600);
      logN <= logN + 1;
    end
    if (pokeEn) mem[pokeAddr[11:2]] <= pokeData;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic regW(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regR(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  function automatic logic [31:0] ctlW(input bit en, input bit fetch, input bit chain,
                                        input bit abort, input logic [2:0] burst,
                                        input logic [1:0] dDir, input logic [1:0] sDir);
    return (32'(abort) << 20) | (32'(fetch) << 13) | (32'(en) << 12) | (32'(chain) << 9) |
           (32'(burst) << 6) | (32'(dDir) << 4) | (32'(sDir) << 2);
  endfunction

  task automatic putDesc(input logic [31:0] at, input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d, input logic [31:0] n);
    poke(at, c); poke(at + 4, s); poke(at + 8, d); poke(at + 12, n);
  endtask

  task automatic waitIrq(input int ch, input string req);
    int k;
    for (k = 0; k < 3000 && !irq[ch]; k++) @(negedge clk);
    check(irq[ch] === 1'b1, req, 32'(irq[ch]), 32'h1);
  endtask

  task automatic waitWrites(input int base, input int n);
    for (int k = 0; k < 3000 && (logN - base) < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    regR(A_CTL, d); check(d == 0, "R1 reset ctl0", d, 0);
    regR(A_CNT + 4, d); check(d == 0, "R1 reset cnt1", d, 0);
    regR(A_STS, d); check(d == 0, "R1 reset sts0", d, 0);
    check(irq == 0 && memReq == 0, "R1 reset outputs", {irq, memReq}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    regW(A_SRC + 4, 32'h1234_5670);
    regR(A_SRC + 4, d); check(d == 32'h1234_5670, "R1 src1 readback", d, 32'h1234_5670);
    regR(A_SRC, d); check(d == 0, "R1 src0 untouched", d, 0);
    regW(A_NXT, 32'h0000_010F);
    regR(A_NXT, d); check(d == 32'h100, "R1 next aligned", d, 32'h100);
    regW(A_MSK + 4, 1);
    regR(A_MSK + 4, d); check(d == 1, "R1 mask1 readback", d, 1);
    regW(A_MSK + 4, 0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    putDesc(32'h100, 16, 32'h200, 32'h300, 32'h100);
    regW(A_MSK, 1); regW(A_NXT, 32'h100);
    regW(A_CTL, ctlW(1, 1, 0, 0, 3'd0, 2'd0, 2'd0));
    waitIrq(0, "R6 single irq");
    for (int k = 0; k < 4; k++)
      check(mem[(32'h300 >> 2) + k] == 32'hA000 + k, "R3 single data", mem[(32'h300 >> 2) + k], 32'hA000 + k);
    regR(A_CNT, d); check(d == 0, "R3 count drained", d, 0);
    regR(A_CUR, d); check(d == 32'h100, "R2 current desc", d, 32'h100);
    regR(A_SRC, d); check(d == 32'h210, "R4 src incremented", d, 32'h210);
    regR(A_CTL, d); check(d[14:12] == 3'b000, "R7 unchained stop", d, 0);
    regR(A_STS, d); check(d == 1, "R6 status set", d, 1);
    regW(A_STS, 0);
    check(irq[0] == 1'b0, "R6 status clear", 32'(irq[0]), 0);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    putDesc(32'h140, 12, 32'h240, 32'h340, 32'h140);
    regW(A_NXT, 32'h140);
    regW(A_CTL, ctlW(1, 1, 0, 0, 3'd0, 2'd0, 2'd2));
    waitIrq(0, "R6 hold-src irq");
    for (int k = 0; k < 3; k++)
      check(mem[(32'h340 >> 2) + k] == 32'hF1F0, "R4 src hold data", mem[(32'h340 >> 2) + k], 32'hF1F0);
    regR(A_SRC, d); check(d == 32'h240, "R4 src held", d, 32'h240);
    regR(A_DST, d); check(d == 32'h34C, "R4 dst stepped", d, 32'h34C);
    regW(A_STS, 0);
    putDesc(32'h150, 12, 32'h200, 32'h380, 32'h150);
    regW(A_NXT, 32'h150);
    regW(A_CTL, ctlW(1, 1, 0, 0, 3'd0, 2'd2, 2'd0));
    waitIrq(0, "R6 hold-dst irq");
    check(mem[32'h380 >> 2] == 32'hA002, "R4 dst hold last word", mem[32'h380 >> 2], 32'hA002);
    check(mem[32'h384 >> 2] == 0, "R4 dst hold no step", mem[32'h384 >> 2], 0);
    regW(A_STS, 0);
  endtask

  task automatic t_roundrobin;
    int base, errs;
    putDesc(32'h180, 16, 32'h200, 32'h400, 32'h180);
    putDesc(32'h190, 16, 32'h220, 32'h500, 32'h190);
    regW(A_NXT, 32'h180); regW(A_NXT + 4, 32'h190);
    base = logN;
    regW(A_CTL, ctlW(1, 1, 0, 0, 3'd0, 2'd0, 2'd0));
    regW(A_CTL + 4, ctlW(1, 1, 0, 0, 3'd0, 2'd0, 2'd0));
    waitWrites(base, 8);
    repeat (10) @(negedge clk);
    errs = 0;
    for (int k = 1; k < 8; k++) if (wlog[base + k] == wlog[base + k - 1]) errs++;
    check(errs == 0 && wlog[base] == 1'b0, "R10 alternating grants", errs, 0);
    check(mem[(32'h500 >> 2) + 3] == 32'hA00B, "R10 ch1 data", mem[(32'h500 >> 2) + 3], 32'hA00B);
    regW(A_STS, 0); regW(A_STS + 4, 0);
  endtask

  task automatic t_burst;
    int base, errs;
    logic [31:0] d;
    bit expSeq [14] = '{0,0,0,0,1,0,0,0,0,1,0,0,1,1};
    putDesc(32'h1A0, 40, 32'h200, 32'h400, 32'h1A0);
    putDesc(32'h1B0, 16, 32'h200, 32'h500, 32'h1B0);
    regW(A_NXT, 32'h1A0); regW(A_NXT + 4, 32'h1B0);
    base = logN;
    regW(A_CTL, ctlW(1, 1, 0, 0, 3'd3, 2'd0, 2'd0));
    regW(A_CTL + 4, ctlW(1, 1, 0, 0, 3'd0, 2'd0, 2'd0));
    waitWrites(base, 14);
    repeat (10) @(negedge clk);
    errs = 0;
    for (int k = 0; k < 14; k++) if (wlog[base + k] != expSeq[k]) errs++;
    check(errs == 0 && logN - base == 14, "R5 burst order", errs, 0);
    regR(A_CNT, d); check(d == 0, "R5 remainder burst drained", d, 0);
    check(mem[(32'h400 >> 2) + 9] == 32'hA009, "R5 last word", mem[(32'h400 >> 2) + 9], 32'hA009);
    regW(A_STS, 0); regW(A_STS + 4, 0);
  endtask

  task automatic t_ring;
    logic [31:0] d;
    int done;
    putDesc(32'h1C0, 8, 32'h200, 32'h600, 32'h1D0);
    putDesc(32'h1D0, 8, 32'h208, 32'h610, 32'h1C0);
    regW(A_MSK, 1); regW(A_NXT, 32'h1C0);
    regW(A_CTL, ctlW(1, 1, 1, 0, 3'd0, 2'd0, 2'd0));
    done = 0;
    for (int k = 0; k < 5; k++) begin
      for (int w = 0; w < 2000 && !irq[0]; w++) @(negedge clk);
      if (irq[0]) begin done++; regW(A_STS, 0); end
    end
    check(done == 5, "R7 ring completions", done, 5);
    regR(A_CTL, d); check(d[12] == 1'b1, "R7 ring still enabled", d, 32'h1000);
    check(mem[(32'h610 >> 2) + 1] == 32'hA003, "R7 second desc data", mem[(32'h610 >> 2) + 1], 32'hA003);
    regW(A_MSK, 0);
    regW(A_CTL, ctlW(1, 0, 1, 1, 3'd0, 2'd0, 2'd0));
    repeat (12) @(negedge clk);
    regW(A_STS, 0);
  endtask

  task automatic t_pause;
    logic [31:0] d, c1, c2;
    int base, r0;
    putDesc(32'h1E0, 64, 32'h200, 32'h700, 32'h1E0);
    regW(A_MSK, 1); regW(A_NXT, 32'h1E0);
    base = logN;
    regW(A_CTL, ctlW(1, 1, 0, 0, 3'd0, 2'd0, 2'd0));
    waitWrites(base, 3);
    regW(A_CTL, ctlW(0, 0, 0, 0, 3'd0, 2'd0, 2'd0));
    repeat (4) @(negedge clk);
    regR(A_CNT, c1); r0 = reqCnt;
    repeat (30) @(negedge clk);
    regR(A_CNT, c2);
    check(c1 == c2 && c1 != 0, "R8 count frozen", c2, c1);
    check(reqCnt == r0, "R8 no requests paused", reqCnt - r0, 0);
    regR(A_CTL, d); check(d[14:12] == 3'b100, "R2 active while paused", d[14:12], 3'b100);
    regW(A_CTL, ctlW(1, 0, 0, 0, 3'd0, 2'd0, 2'd0));
    waitIrq(0, "R8 resume completes");
    for (int k = 0; k < 16; k++)
      check(mem[(32'h700 >> 2) + k] == 32'hA000 + k, "R8 resumed data", mem[(32'h700 >> 2) + k], 32'hA000 + k);
    regW(A_STS, 0); regW(A_MSK, 0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    int base, r0;
    putDesc(32'h1F0, 64, 32'h200, 32'h800, 32'h1F0);
    regW(A_MSK, 1); regW(A_NXT, 32'h1F0);
    base = logN;
    regW(A_CTL, ctlW(1, 1, 1, 0, 3'd0, 2'd0, 2'd0));
    waitWrites(base, 3);
    regW(A_CTL, ctlW(1, 0, 1, 1, 3'd0, 2'd0, 2'd0));
    repeat (10) @(negedge clk);
    regR(A_CTL, d); check(d[20] == 0 && d[14:12] == 0, "R9 abort clears enable", d, 0);
    regR(A_CNT, d); check(d != 0, "R9 aborted mid descriptor", d, 32'h1);
    regR(A_STS, d); check(d == 0 && irq[0] == 0, "R9 no completion", d, 0);
    r0 = reqCnt;
    repeat (30) @(negedge clk);
    check(reqCnt == r0, "R9 port quiet", reqCnt - r0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    for (int k = 0; k < 16; k++) poke(32'h200 + 4 * k, 32'hA000 + k);
    poke(32'h240, 32'hF1F0);
    t_regmap();
    t_single();
    t_hold();
    t_roundrobin();
    t_burst();
    t_ring();
    t_pause();
    t_abort();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule